// File: doc/BRIEF.md
# Multiplexed ADC Scan Slot Scheduler

This block decides, slot by slot, which input a single shared ADC converts. Each scan loop is eight equal time slots. The first seven slots convert battery cells one to seven in order. The eighth slot is shared among five auxiliary inputs: thermistor, die temperature, stack top, reference and ground. It converts one of them per loop, taking them in turn, so all five are covered once in every five loops (one full scan). The slot length is chosen by a 2-bit speed field. A 2-bit slow-down field stretches the loop by inserting idle slots after every active slot, which saves power. The ADC sits outside the block. It sees a one-cycle convert-start strobe and a registered channel code.

Slot time is counted in clock cycles. One base unit is `UNIT_CYC` cycles, and a slot lasts 8, 4, 2 or 1 units for speed codes 0, 1, 2 and 3. `UNIT_CYC` must be at least 2.

The control is a three-state machine:
- `ST_OFF`: the block is disabled.
- `ST_ACTIVE`: a conversion slot is running.
- `ST_IDLE`: a power-saving gap slot is running.

Its transitions are:
- **enable**: `ST_OFF` to `ST_ACTIVE`, slot 0, configuration latched.
- **stretch**: `ST_ACTIVE` to `ST_IDLE` at the end of a slot when the slow-down field is non-zero.
- **gap**: `ST_IDLE` to `ST_IDLE` while idle slots remain.
- **advance**: `ST_ACTIVE` or `ST_IDLE` to `ST_ACTIVE`, next slot, after the last slot of the group ends.
- **wrap**: an advance out of slot 7. It begins a new loop and re-latches the configuration.
- **disable**: any state to `ST_OFF` when `en` is low.

Top module: `scan_slot_sched`

## Requirements
- R1: While `en` is low, from the cycle after it is sampled low, `conv_start`, `slot_active`, `loop_done` and `scan_done` are 0. After reset all outputs are 0.
- R2: Within a loop, active slots 0 to 6 issue channel codes 0 to 6 in that order.
- R3: Active slot 7 issues code 7 + k, where k counts loops since enable modulo 5. The codes run 7 to 11 (thermistor, die temperature, stack top, reference, ground) and then wrap to 7.
- R4: An active slot lasts `UNIT_CYC << (3 - speed)` cycles, and `slot_active` is 1 throughout it.
- R5: After each active slot come `2^slow - 1` idle slots of the same length. During these, `slot_active` and `conv_start` are 0.
- R6: `conv_start` is 1 for exactly the first cycle of every active slot, with `chan_sel` valid in that same cycle.
- R7: `loop_done` is 1 for one cycle, in the first cycle after the last slot of a loop (including its idle slots) ends. That is the cycle in which slot 0 of the next loop starts.
- R8: `scan_done` is 1 together with `loop_done` only at the end of every fifth loop since enable.
- R9: Values applied to `speed_sel` and `slow_sel` mid-loop do not change that loop's timing. They take effect from the next loop.
- R10: After `en` is dropped and raised again, scanning restarts at slot 0 and the shared slot restarts at code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Scheduler enable |
| speed_sel | input | 2 | Slot-length code (0 longest, 3 shortest) |
| slow_sel | input | 2 | Idle-stretch code (2^code - 1 idle slots) |
| chan_sel | output | 4 | Channel code of the current conversion |
| conv_start | output | 1 | One-cycle convert-start strobe |
| slot_active | output | 1 | High during active (converting) slots |
| loop_done | output | 1 | One-cycle end-of-loop flag |
| scan_done | output | 1 | One-cycle end-of-full-scan flag |

## Verification
The assertions take for granted that `UNIT_CYC` is at least 2, so two start strobes can never fall in adjacent cycles. They also assume the configuration fields may change at any time, while the latched copies inside the block change only at a loop wrap. The stimulus drives `en`, `speed_sel` and `slow_sel` only on falling clock edges, and the bench uses a two-cycle base unit. It sweeps all sixteen speed and slow-down pairs over six loops each, so the shared slot wraps. It also changes the configuration in the middle of a loop and drops `en` in the middle of a scan.

// File: rtl/scan_sched_pkg.sv
package scan_sched_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_IDLE   = 2'd2
    } sched_state_e;

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int UNIT_CYC = 4,
    parameter int CFG_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CFG_W-1:0] speed,
    output logic             last
);
    localparam int SH_MAX  = (1 << CFG_W) - 1;
    localparam int MAX_LEN = UNIT_CYC << SH_MAX;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_m1;

    // Slot length halves with each step of the speed code.
    always_comb begin
        len_m1 = CNT_W'((UNIT_CYC << (SH_MAX - int'(speed))) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q == len_m1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == len_m1);

    // R4: the in-slot count never runs past the selected length.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= len_m1));

    // R4: every completed slot leaves the count at its start.
    p_cnt_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt_q == '0));

endmodule

// File: rtl/aux_rotator.sv
module aux_rotator #(
    parameter int N_AUX = 5,
    parameter int IDX_W = $clog2(N_AUX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);
    logic [IDX_W-1:0] idx_q;

    assign at_last = (int'(idx_q) == N_AUX - 1);
    assign idx     = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= at_last ? '0 : idx_q + 1'b1;
        end
    end

    // R3: the shared-source index stays within the source list.
    p_aux_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx_q) < N_AUX);

    // R3: after the final source the rotation returns to the first.
    p_aux_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_last && !clr) |=> (idx_q == '0));

    // R10: a clear always lands on the first source.
    p_aux_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (idx_q == '0));

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_sched_pkg::*;
#(
    parameter int N_CELLS = 7,
    parameter int N_AUX   = 5,
    parameter int CFG_W   = 2,
    parameter int IDX_W   = $clog2(N_AUX),
    parameter int CHAN_W  = $clog2(N_CELLS + N_AUX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CFG_W-1:0]  speed,
    input  logic [CFG_W-1:0]  slow,
    input  logic              slot_end,
    input  logic [IDX_W-1:0]  aux_idx,
    input  logic              aux_last,
    output logic              sched_off,
    output logic [CFG_W-1:0]  spd_cur,
    output logic              aux_adv,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              conv_start,
    output logic              slot_active,
    output logic              loop_done,
    output logic              scan_done
);
    localparam int SLOT_W = $clog2(N_CELLS + 1);
    localparam int IDLE_W = (1 << CFG_W) - 1;

    sched_state_e      state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [IDLE_W-1:0] idle_q, idle_d;
    logic [CFG_W-1:0]  spd_q, spd_d;
    logic [CFG_W-1:0]  slw_q, slw_d;

    logic              start_q, start_d;
    logic              act_q, act_d;
    logic [CHAN_W-1:0] chan_q, chan_d;
    logic              ldone_q, ldone_d;
    logic              sdone_q, sdone_d;
    logic              wrap_d;

    // Next-state and next-output decode.
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        idle_d  = idle_q;
        spd_d   = spd_q;
        slw_d   = slw_q;
        start_d = 1'b0;
        act_d   = (state_q == ST_ACTIVE);
        chan_d  = chan_q;
        ldone_d = 1'b0;
        sdone_d = 1'b0;
        wrap_d  = 1'b0;

        unique case (state_q)
            ST_OFF: begin
                if (en) begin
                    // enable
                    state_d = ST_ACTIVE;
                    slot_d  = '0;
                    idle_d  = '0;
                    spd_d   = speed;
                    slw_d   = slow;
                    start_d = 1'b1;
                    act_d   = 1'b1;
                    chan_d  = '0;
                end
            end
            ST_ACTIVE, ST_IDLE: begin
                if (!en) begin
                    // disable
                    state_d = ST_OFF;
                    slot_d  = '0;
                    idle_d  = '0;
                    spd_d   = '0;
                    slw_d   = '0;
                    act_d   = 1'b0;
                    chan_d  = '0;
                end else if (slot_end) begin
                    if (state_q == ST_ACTIVE && slw_q != '0) begin
                        // stretch
                        state_d = ST_IDLE;
                        idle_d  = IDLE_W'((1 << slw_q) - 1);
                        act_d   = 1'b0;
                    end else if (state_q == ST_IDLE && idle_q > IDLE_W'(1)) begin
                        // gap
                        idle_d  = idle_q - 1'b1;
                    end else begin
                        // advance
                        state_d = ST_ACTIVE;
                        idle_d  = '0;
                        start_d = 1'b1;
                        act_d   = 1'b1;
                        if (int'(slot_q) == N_CELLS) begin
                            // wrap
                            wrap_d  = 1'b1;
                            slot_d  = '0;
                            chan_d  = '0;
                            ldone_d = 1'b1;
                            sdone_d = aux_last;
                            spd_d   = speed;
                            slw_d   = slow;
                        end else begin
                            slot_d = slot_q + 1'b1;
                            if (int'(slot_q) + 1 == N_CELLS) begin
                                chan_d = CHAN_W'(N_CELLS) + CHAN_W'(aux_idx);
                            end else begin
                                chan_d = CHAN_W'(slot_q) + 1'b1;
                            end
                        end
                    end
                end
            end
            default: begin
                state_d = ST_OFF;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            slot_q  <= '0;
            idle_q  <= '0;
            spd_q   <= '0;
            slw_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            idle_q  <= idle_d;
            spd_q   <= spd_d;
            slw_q   <= slw_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            act_q   <= 1'b0;
            chan_q  <= '0;
            ldone_q <= 1'b0;
            sdone_q <= 1'b0;
        end else begin
            start_q <= start_d;
            act_q   <= act_d;
            chan_q  <= chan_d;
            ldone_q <= ldone_d;
            sdone_q <= sdone_d;
        end
    end

    assign sched_off   = (state_q == ST_OFF);
    assign spd_cur     = spd_q;
    assign aux_adv     = wrap_d;
    assign chan_sel    = chan_q;
    assign conv_start  = start_q;
    assign slot_active = act_q;
    assign loop_done   = ldone_q;
    assign scan_done   = sdone_q;

    // R1: a low enable silences every strobe on the next cycle.
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!conv_start && !slot_active && !loop_done && !scan_done));

    // R6: the convert strobe lasts a single cycle.
    p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R6: a strobe only opens an active slot.
    p_start_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> slot_active);

    // R5: in a gap slot nothing converts.
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!slot_active && !conv_start));

    // R7: a loop ends exactly as cell slot 0 begins.
    p_loop_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |-> (conv_start && chan_sel == '0));

    // R8: a full scan ends only on a loop end.
    p_scan_loop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> loop_done);

    // R3: shared-slot codes stay within the auxiliary range.
    p_shared_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && int'(chan_sel) >= N_CELLS) |-> (int'(chan_sel) < N_CELLS + N_AUX));

    // R9: latched timing holds for the whole loop.
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sched_off && !aux_adv) |=> ($stable(spd_q) && $stable(slw_q)));

endmodule

// File: rtl/scan_slot_sched.sv
module scan_slot_sched #(
    parameter int UNIT_CYC = 4,
    parameter int N_CELLS  = 7,
    parameter int N_AUX    = 5,
    parameter int CFG_W    = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  en,
    input  logic [CFG_W-1:0]                      speed_sel,
    input  logic [CFG_W-1:0]                      slow_sel,
    output logic [$clog2(N_CELLS + N_AUX)-1:0]    chan_sel,
    output logic                                  conv_start,
    output logic                                  slot_active,
    output logic                                  loop_done,
    output logic                                  scan_done
);
    localparam int IDX_W  = $clog2(N_AUX);
    localparam int CHAN_W = $clog2(N_CELLS + N_AUX);

    logic             slot_end;
    logic             sched_off;
    logic [CFG_W-1:0] spd_cur;
    logic             aux_adv;
    logic [IDX_W-1:0] aux_idx;
    logic             aux_last;

    slot_timer #(
        .UNIT_CYC (UNIT_CYC),
        .CFG_W    (CFG_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!sched_off),
        .speed (spd_cur),
        .last  (slot_end)
    );

    aux_rotator #(
        .N_AUX (N_AUX),
        .IDX_W (IDX_W)
    ) u_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sched_off),
        .adv     (aux_adv),
        .idx     (aux_idx),
        .at_last (aux_last)
    );

    scan_fsm #(
        .N_CELLS (N_CELLS),
        .N_AUX   (N_AUX),
        .CFG_W   (CFG_W),
        .IDX_W   (IDX_W),
        .CHAN_W  (CHAN_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .speed       (speed_sel),
        .slow        (slow_sel),
        .slot_end    (slot_end),
        .aux_idx     (aux_idx),
        .aux_last    (aux_last),
        .sched_off   (sched_off),
        .spd_cur     (spd_cur),
        .aux_adv     (aux_adv),
        .chan_sel    (chan_sel),
        .conv_start  (conv_start),
        .slot_active (slot_active),
        .loop_done   (loop_done),
        .scan_done   (scan_done)
    );

endmodule

// File: tb/tb_scan_slot_sched.sv
`timescale 1ns/1ps
module tb_scan_slot_sched;
    localparam int UNIT = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [1:0] speed_sel;
    logic [1:0] slow_sel;
    logic [3:0] chan_sel;
    logic       conv_start;
    logic       slot_active;
    logic       loop_done;
    logic       scan_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    scan_slot_sched #(.UNIT_CYC(UNIT)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .speed_sel   (speed_sel),
        .slow_sel    (slow_sel),
        .chan_sel    (chan_sel),
        .conv_start  (conv_start),
        .slot_active (slot_active),
        .loop_done   (loop_done),
        .scan_done   (scan_done)
    );

    function automatic string pick(string forced, string dflt);
        return (forced != "") ? forced : dflt;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // R1: all strobes quiet while disabled.
    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(conv_start == 1'b0,  req, "conv_start",  int'(conv_start),  0);
            chk(slot_active == 1'b0, req, "slot_active", int'(slot_active), 0);
            chk(loop_done == 1'b0,   req, "loop_done",   int'(loop_done),   0);
            chk(scan_done == 1'b0,   req, "scan_done",   int'(scan_done),   0);
        end
    endtask

    // Arithmetic model of one stretch of scanning at a fixed timing.
    task automatic run_seg(input int sp, input int sl, input int ncyc, input int lp0,
                           input int chg_at, input int nsp, input int nsl,
                           input string tag);
        int len, grp, lp_len, r, q, slot, abs_lp, e_chan;
        bit e_start, e_act, e_ld, e_sd;
        len    = UNIT << (3 - sp);
        grp    = len << sl;
        lp_len = 8 * grp;
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            abs_lp  = lp0 + t / lp_len;
            r       = t % lp_len;
            slot    = r / grp;
            q       = r % grp;
            e_act   = (q < len);
            e_start = (q == 0);
            e_ld    = (r == 0) && (abs_lp > 0);
            e_sd    = e_ld && (abs_lp % 5 == 0);
            e_chan  = (slot < 7) ? slot : 7 + (abs_lp % 5);
            chk(conv_start == e_start, pick(tag, e_act ? "R6" : "R5"), "conv_start",
                int'(conv_start), int'(e_start));
            chk(slot_active == e_act, pick(tag, e_act ? "R4" : "R5"), "slot_active",
                int'(slot_active), int'(e_act));
            if (e_start) begin
                chk(int'(chan_sel) == e_chan, pick(tag, (slot < 7) ? "R2" : "R3"),
                    "chan_sel", int'(chan_sel), e_chan);
            end
            chk(loop_done == e_ld, pick(tag, "R7"), "loop_done", int'(loop_done), int'(e_ld));
            chk(scan_done == e_sd, pick(tag, "R8"), "scan_done", int'(scan_done), int'(e_sd));
            if (t == chg_at) begin
                speed_sel = 2'(nsp);
                slow_sel  = 2'(nsl);
            end
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        en        = 1'b0;
        speed_sel = 2'd0;
        slow_sel  = 2'd0;
        repeat (4) @(negedge clk);
        chk(conv_start == 1'b0 && slot_active == 1'b0 && chan_sel == 4'd0 &&
            loop_done == 1'b0 && scan_done == 1'b0, "R1", "reset outputs",
            int'({conv_start, slot_active, loop_done, scan_done}), 0);
        rst_n = 1'b1;
        quiet(3, "R1");

        // Sweep every speed and slow-down pair over six loops (R2 to R8).
        for (int sp = 0; sp < 4; sp++) begin
            for (int sl = 0; sl < 4; sl++) begin
                speed_sel = 2'(sp);
                slow_sel  = 2'(sl);
                en        = 1'b1;
                run_seg(sp, sl, 6 * 8 * ((UNIT << (3 - sp)) << sl), 0, -1, 0, 0, "");
                en = 1'b0;
                quiet(2, "R1");
            end
        end

        // R9: a mid-loop change waits for the loop wrap.
        speed_sel = 2'd0;
        slow_sel  = 2'd0;
        en        = 1'b1;
        run_seg(0, 0, 128, 0, 40, 3, 1, "R9");
        run_seg(3, 1, 64, 1, -1, 0, 0, "R9");
        en = 1'b0;
        quiet(2, "R1");

        // R10: abort mid-scan, then restart from slot 0 and source 7.
        speed_sel = 2'd2;
        slow_sel  = 2'd1;
        en        = 1'b1;
        run_seg(2, 1, 64 + 37, 0, -1, 0, 0, "");
        en = 1'b0;
        quiet(3, "R10");
        en = 1'b1;
        run_seg(2, 1, 128, 0, -1, 0, 0, "R10");
        en = 1'b0;
        quiet(2, "R1");

        finish_run();
    end

endmodule